// File: doc/BRIEF.md
# PHY Management Serial Master with Command Word Port

This block runs read and write transactions against the management registers of an Ethernet PHY. It uses the two-wire management bus: a clock line (MDC) and a bidirectional data line (MDIO). A transaction carries a 5-bit PHY address, a 5-bit register address, a direction and, for writes, a 16-bit value. The block serialises the whole frame, bit by bit:

- a long run of ones;
- the start and opcode pairs;
- both addresses;
- the turnaround;
- the data phase.

On a read it takes the line back from the PHY and shifts the returned word in.

A transaction can be started through either of two fronts:

- **Direct request port.** A single-cycle `req_valid` with separate fields.
- **Packed 32-bit command word.** Software-style logic writes this word and then polls its done flag. The same word, read back, shows the fields of the last accepted transaction, an in-progress bit for each direction and the read-done flag.

Only one transaction is in flight at a time. Anything presented while one runs is dropped.

MDC runs only during a frame. Each bit holds MDC low for `HALF_DIV` clocks and then high for `HALF_DIV` clocks. Data changes only at the falling edge, so it is set up while the clock is low. Read data is sampled at the end of the high half.

Top module: `mdio_dual_master`

## Requirements
- R1: Every frame opens with `PRE_LEN` (default 35) MDC cycles in which `mdio_oe`=1 and `mdio_o`=1.
- R2: After the ones, the frame drives the start pair 0 then 1, followed by the opcode pair: 0,1 for a write and 1,0 for a read.
- R3: Next come the 5-bit PHY address and then the 5-bit register address, each most significant bit first.
- R4: A write drives turnaround 1 then 0 and then the 16 data bits, most significant first. `mdio_oe` stays 1 throughout, so the frame is `PRE_LEN`+32 MDC cycles long.
- R5: A read holds `mdio_oe` at 1 through the register address. It then holds `mdio_oe` at 0 for one turnaround cycle and all 16 data cycles, so the frame is `PRE_LEN`+31 MDC cycles long.
- R6: On a read, `mdio_i` is sampled at the end of the high half of each of the 16 data cycles, most significant bit first. The turnaround cycle is not sampled. The captured word appears on `rd_data` in the cycle where `done` pulses, and also in `cmd_rdata[15:0]`.
- R7: Command word layout:
  - bits 25:21 hold the PHY address, bits 20:16 the register address and bits 15:0 the data;
  - writing bit 27 starts a read, and writing bit 26 starts a write;
  - if both bits are set, the word starts a read;
  - a word with neither bit set, or with any of bits 31:28 set, has no effect.
  
  While a transaction runs, `cmd_rdata` bit 27 (read in progress) or bit 26 (write in progress) reads as 1.
- R8: `cmd_rdata[28]` becomes 1 in the cycle after a read completes. It returns to 0 in the cycle after any new transaction is accepted.
- R9: Any command word or direct request presented while `busy`=1 is ignored. When both fronts request in the same idle cycle, the command word wins.
- R10: Each MDC cycle is `HALF_DIV` clocks low followed by `HALF_DIV` clocks high, and MDIO changes only while MDC is low. When idle, MDC=0 and `mdio_oe`=0.
- R11: `busy` rises in the cycle after acceptance. `done` is a single-cycle pulse in the cycle where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Direct request strobe |
| req_write | input | 1 | Direct request direction, 1 = write |
| req_phy | input | 5 | Direct request PHY address |
| req_reg | input | 5 | Direct request register address |
| req_wdata | input | 16 | Direct request write data |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word value |
| cmd_rdata | output | 32 | Command and status view |
| busy | output | 1 | Transaction in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The hardest situation to reach from the ports is a collision: a request arriving while a frame is already on the wire, or both fronts firing in the same idle cycle. A bad arbiter would either corrupt the running frame or silently start a second one. The bench launches a frame and then fires both fronts mid-frame. It then rebuilds the frame from MDC edges and confirms that it matches the original transaction and that nothing follows. A bench-side PHY model drives `mdio_i` only during read data cycles. It drives a 1 during the turnaround, so a capture that is off by one bit position becomes visible in the returned word.

// File: rtl/mdio_dual_pkg.sv
package mdio_dual_pkg;
   localparam int ADR_W        = 5;
   localparam int DAT_W        = 16;
   localparam int HDR_BITS     = 14;
   localparam int CW_PHY_LSB   = 21;
   localparam int CW_REG_LSB   = 16;
   localparam int CW_WR_BIT    = 26;
   localparam int CW_RD_BIT    = 27;
   localparam int CW_DONE_BIT  = 28;

   typedef struct packed {
      logic             wr;
      logic [ADR_W-1:0] phy;
      logic [ADR_W-1:0] regad;
      logic [DAT_W-1:0] data;
   } mdio_txn_t;
endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic end_high
);
   logic hi;
   logic end_phase;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_single
      assign end_phase = run;
   end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)                cnt <= '0;
         else if (!run || end_phase) cnt <= '0;
         else                       cnt <= cnt + 1'b1;
      end
      assign end_phase = run && (cnt == TOP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         hi <= 1'b0;
      else if (!run)      hi <= 1'b0;
      else if (end_phase) hi <= !hi;
   end

   assign mdc      = hi;
   assign end_high = end_phase && hi;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_dual_pkg::*;
#(
   parameter int PRE_LEN = 35
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  mdio_txn_t        txn,
   input  logic             end_high,
   input  logic             mdio_i,
   output logic             busy,
   output logic             is_wr,
   output logic             mdio_o,
   output logic             mdio_oe,
   output logic             done,
   output logic [DAT_W-1:0] rdata
);
   localparam int IDX_W = $clog2(PRE_LEN + 33);
   localparam logic [IDX_W-1:0] PRE_END   = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] OE_CUT    = IDX_W'(PRE_LEN + HDR_BITS);
   localparam logic [IDX_W-1:0] SAMP_FROM = IDX_W'(PRE_LEN + HDR_BITS + 1);
   localparam logic [IDX_W-1:0] LAST_WR   = IDX_W'(PRE_LEN + 31);
   localparam logic [IDX_W-1:0] LAST_RD   = IDX_W'(PRE_LEN + 30);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end

   logic [IDX_W-1:0] idx;
   logic [31:0]      sh;
   logic             last_bit;

   assign last_bit = is_wr ? (idx == LAST_WR) : (idx == LAST_RD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         is_wr <= 1'b0;
         idx   <= '0;
         sh    <= '0;
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy  <= 1'b1;
            is_wr <= txn.wr;
            idx   <= '0;
            sh    <= txn.wr ? {2'b01, 2'b01, txn.phy, txn.regad, 2'b10, txn.data}
                            : {2'b01, 2'b10, txn.phy, txn.regad, 18'b0};
         end else if (busy && end_high) begin
            if (!is_wr && idx >= SAMP_FROM)
               rdata <= {rdata[DAT_W-2:0], mdio_i};
            if (last_bit) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
               if (idx >= PRE_END) sh <= {sh[30:0], 1'b0};
            end
         end
      end
   end

   assign mdio_oe = busy && (is_wr || idx < OE_CUT);
   assign mdio_o  = mdio_oe && ((idx < PRE_END) || sh[31]);

   // R11: completion pulse only follows a running frame
   p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));
endmodule

// File: rtl/mdio_cmd_port.sv
module mdio_cmd_port
   import mdio_dual_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [ADR_W-1:0] req_phy,
   input  logic [ADR_W-1:0] req_reg,
   input  logic [DAT_W-1:0] req_wdata,
   input  logic             cmd_we,
   input  logic [31:0]      cmd_wdata,
   input  logic             eng_busy,
   input  logic             eng_is_wr,
   input  logic             eng_done,
   input  logic [DAT_W-1:0] eng_rdata,
   output logic             start,
   output mdio_txn_t        txn,
   output logic [31:0]      cmd_rdata
);
   logic             reserved_set;
   logic             cmd_go;
   logic             dir_go;
   logic [ADR_W-1:0] f_phy;
   logic [ADR_W-1:0] f_reg;
   logic [DAT_W-1:0] f_data;
   logic             done_flag;

   assign reserved_set = |cmd_wdata[31:CW_DONE_BIT];
   assign cmd_go = cmd_we && !eng_busy && !reserved_set
                   && (cmd_wdata[CW_RD_BIT] || cmd_wdata[CW_WR_BIT]);
   assign dir_go = req_valid && !eng_busy && !cmd_go;
   assign start  = cmd_go || dir_go;

   always_comb begin
      if (cmd_go) begin
         txn.wr    = !cmd_wdata[CW_RD_BIT];
         txn.phy   = cmd_wdata[CW_PHY_LSB +: ADR_W];
         txn.regad = cmd_wdata[CW_REG_LSB +: ADR_W];
         txn.data  = cmd_wdata[DAT_W-1:0];
      end else begin
         txn.wr    = req_write;
         txn.phy   = req_phy;
         txn.regad = req_reg;
         txn.data  = req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_phy     <= '0;
         f_reg     <= '0;
         f_data    <= '0;
         done_flag <= 1'b0;
      end else if (start) begin
         f_phy     <= txn.phy;
         f_reg     <= txn.regad;
         f_data    <= txn.data;
         done_flag <= 1'b0;
      end else if (eng_done && !eng_is_wr) begin
         f_data    <= eng_rdata;
         done_flag <= 1'b1;
      end
   end

   assign cmd_rdata = {3'b000, done_flag, eng_busy && !eng_is_wr, eng_busy && eng_is_wr,
                       f_phy, f_reg, f_data};

   // R9: addresses in the status view hold while a frame runs
   p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> $stable(f_phy) && $stable(f_reg));
   // R8: acceptance clears the done flag
   p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !cmd_rdata[CW_DONE_BIT]);
   // R8: read completion sets the done flag
   p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && !eng_is_wr && !start |=> cmd_rdata[CW_DONE_BIT]);
endmodule

// File: rtl/mdio_dual_master.sv
module mdio_dual_master
   import mdio_dual_pkg::*;
#(
   parameter int PRE_LEN  = 35,
   parameter int HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   input  logic        cmd_we,
   input  logic [31:0] cmd_wdata,
   output logic [31:0] cmd_rdata,
   output logic        busy,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic      start;
   mdio_txn_t txn;
   logic      eng_is_wr;
   logic      end_high;

   mdio_cmd_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_phy   (req_phy),
      .req_reg   (req_reg),
      .req_wdata (req_wdata),
      .cmd_we    (cmd_we),
      .cmd_wdata (cmd_wdata),
      .eng_busy  (busy),
      .eng_is_wr (eng_is_wr),
      .eng_done  (done),
      .eng_rdata (rd_data),
      .start     (start),
      .txn       (txn),
      .cmd_rdata (cmd_rdata)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .txn      (txn),
      .end_high (end_high),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .is_wr    (eng_is_wr),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done     (done),
      .rdata    (rd_data)
   );

   mdio_bit_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .end_high (end_high)
   );

   // R10: data line is held while the clock stays high
   p_mdio_stable_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
   // R10: idle bus keeps the clock low and the line released
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc && !mdio_oe);
endmodule

// File: tb/tb_mdio_dual_master.sv
`timescale 1ns/1ps
module tb_mdio_dual_master;
   localparam int PRE  = 35;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [4:0]  req_phy = '0, req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        cmd_we = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;
   logic        mdio_i = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // monitor state
   bit          mon_wr = 1'b0;
   logic [15:0] mon_resp = '0;
   int          nrise = 0;
   logic        rec_o [0:127];
   logic        rec_oe[0:127];
   logic        prev_mdc = 1'b0, prev_busy = 1'b0;
   int          hi_run = 0, lo_run = 0, run_bad = 0;

   always #4 clk = ~clk;

   mdio_dual_master #(.PRE_LEN(PRE), .HALF_DIV(HALF)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   // bus monitor and PHY model, sampling between active edges
   always @(negedge clk) begin
      if (busy && !prev_busy) begin
         nrise  = 0;
         lo_run = 0;
      end
      if (mdc && !prev_mdc) begin
         if (busy && lo_run != HALF) run_bad++;
         lo_run = 0;
         if (nrise < 128) begin
            rec_o[nrise]  = mdio_o;
            rec_oe[nrise] = mdio_oe;
         end
         if (!mon_wr) begin
            int k;
            k = nrise - PRE;
            if (k >= 15 && k <= 30) mdio_i = mon_resp[30-k];
            else                    mdio_i = (k == 14);
         end else begin
            mdio_i = 1'b0;
         end
         nrise++;
      end
      if (mdc) hi_run++;
      else begin
         if (prev_mdc && hi_run != HALF) run_bad++;
         hi_run = 0;
         if (busy) lo_run++;
      end
      prev_mdc  = mdc;
      prev_busy = busy;
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_bit(input int n, input bit wr, input logic [4:0] p,
                                          input logic [4:0] r, input logic [15:0] d);
      logic [13:0] hdr;
      logic [17:0] tail;
      int k;
      hdr  = {2'b01, (wr ? 2'b01 : 2'b10), p, r};
      tail = {2'b10, d};
      if (n < PRE) return 2'b11;
      k = n - PRE;
      if (k < 14) return {1'b1, hdr[13-k]};
      if (wr) return {1'b1, tail[17-(k-14)]};
      return 2'b00;
   endfunction

   task automatic check_frame(input bit wr, input logic [4:0] p, input logic [4:0] r,
                              input logic [15:0] d);
      int nexp;
      int e_pre, e_so, e_adr, e_tail;
      nexp = PRE + (wr ? 32 : 31);
      e_pre = 0; e_so = 0; e_adr = 0; e_tail = 0;
      chk(nrise == nexp, wr ? "R4" : "R5", "frame length", nrise, nexp);
      for (int n = 0; n < nexp && n < 128; n++) begin
         logic [1:0] e;
         bit ok;
         e  = exp_bit(n, wr, p, r, d);
         ok = (rec_oe[n] === e[1]) && (!e[1] || rec_o[n] === e[0]);
         if (!ok) begin
            if (n < PRE)           e_pre++;
            else if (n < PRE + 4)  e_so++;
            else if (n < PRE + 14) e_adr++;
            else                   e_tail++;
         end
      end
      chk(e_pre == 0, "R1", "preamble bit errors", e_pre, 0);
      chk(e_so == 0, "R2", "start/opcode bit errors", e_so, 0);
      chk(e_adr == 0, "R3", "address bit errors", e_adr, 0);
      chk(e_tail == 0, wr ? "R4" : "R5", "turnaround/data bit errors", e_tail, 0);
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 5000) chk(1'b0, "R11", "watchdog waiting for done", 0, 1);
      else chk(!busy, "R11", "busy low at done", busy, 0);
   endtask

   task automatic launch(input bit via_cmd, input bit wr, input logic [4:0] p,
                         input logic [4:0] r, input logic [15:0] d, input logic [15:0] resp);
      mon_wr   = wr;
      mon_resp = resp;
      @(negedge clk);
      if (via_cmd) begin
         cmd_we    = 1'b1;
         cmd_wdata = {4'b0000, !wr, wr, p, r, d};
      end else begin
         req_valid = 1'b1;
         req_write = wr;
         req_phy   = p;
         req_reg   = r;
         req_wdata = d;
      end
      @(negedge clk);
      cmd_we    = 1'b0;
      req_valid = 1'b0;
      chk(busy === 1'b1, "R11", "busy after accept", busy, 1);
      chk(cmd_rdata[27:26] === (wr ? 2'b01 : 2'b10), "R7", "in-progress bits",
          cmd_rdata[27:26], wr ? 2'b01 : 2'b10);
      chk(cmd_rdata[28] === 1'b0, "R8", "done flag cleared on accept", cmd_rdata[28], 0);
   endtask

   task automatic finish_txn(input bit wr, input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] d, input logic [15:0] resp);
      wait_done();
      check_frame(wr, p, r, d);
      if (!wr) chk(rd_data === resp, "R6", "rd_data at done", rd_data, resp);
      @(negedge clk);
      chk(done === 1'b0, "R11", "done is one cycle", done, 0);
      chk(cmd_rdata[25:16] === {p, r}, "R7", "address fields in status", cmd_rdata[25:16], {p, r});
      if (!wr) begin
         chk(cmd_rdata[28] === 1'b1, "R8", "done flag after read", cmd_rdata[28], 1);
         chk(cmd_rdata[15:0] === resp, "R6", "read word in status", cmd_rdata[15:0], resp);
      end else begin
         chk(cmd_rdata[28] === 1'b0, "R8", "done flag after write", cmd_rdata[28], 0);
         chk(cmd_rdata[15:0] === d, "R7", "write word in status", cmd_rdata[15:0], d);
      end
   endtask

   task automatic txn(input bit via_cmd, input bit wr, input logic [4:0] p,
                      input logic [4:0] r, input logic [15:0] d, input logic [15:0] resp);
      launch(via_cmd, wr, p, r, d, resp);
      finish_txn(wr, p, r, d, resp);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R11 global watchdog expired actual=0 expected=1");
      summary();
   end

   initial begin
      int unsigned sd;
      logic [31:0] snap;
      sd = $urandom(32'd20240611);
      repeat (5) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R11", "reset busy/done", {busy, done}, 0);
      chk(mdc === 1'b0 && mdio_oe === 1'b0, "R10", "reset bus idle", {mdc, mdio_oe}, 0);
      chk(cmd_rdata === 32'h0, "R7", "reset status word", cmd_rdata, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(mdc === 1'b0 && mdio_oe === 1'b0, "R10", "idle after reset", {mdc, mdio_oe}, 0);

      // directed frames with extreme field values
      txn(1'b0, 1'b1, 5'h1F, 5'h00, 16'hA55A, 16'h0);
      txn(1'b0, 1'b0, 5'h00, 5'h1F, 16'h0, 16'hC3A5);
      txn(1'b1, 1'b0, 5'h15, 5'h0A, 16'h0, 16'h8001);
      txn(1'b1, 1'b1, 5'h0A, 5'h15, 16'hFFFF, 16'h0);

      // R7: both start bits -> read frame
      mon_wr = 1'b0; mon_resp = 16'h1234;
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = {4'b0000, 1'b1, 1'b1, 5'h03, 5'h04, 16'hBEEF};
      @(negedge clk);
      cmd_we = 1'b0;
      chk(cmd_rdata[27:26] === 2'b10, "R7", "both bits start a read", cmd_rdata[27:26], 2'b10);
      finish_txn(1'b0, 5'h03, 5'h04, 16'h0, 16'h1234);

      // R7: neither start bit, and reserved bit set: no effect
      snap = cmd_rdata;
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = {4'b0000, 2'b00, 5'h07, 5'h07, 16'h7777};
      @(negedge clk);
      cmd_wdata = {4'b0100, 2'b01, 5'h07, 5'h07, 16'h7777};
      @(negedge clk);
      cmd_we = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy === 1'b0 && mdc === 1'b0, "R7", "ignored words start nothing", {busy, mdc}, 0);
      chk(cmd_rdata === snap, "R7", "ignored words leave status", cmd_rdata, snap);

      // R9: requests on both fronts while busy are dropped
      launch(1'b0, 1'b1, 5'h11, 5'h02, 16'h0F0F, 16'h0);
      repeat (40) @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = {4'b0000, 2'b10, 5'h1E, 5'h1D, 16'h0};
      req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h1C; req_reg = 5'h1B;
      @(negedge clk);
      cmd_we = 1'b0; req_valid = 1'b0;
      finish_txn(1'b1, 5'h11, 5'h02, 16'h0F0F, 16'h0);
      repeat (6) @(negedge clk);
      chk(busy === 1'b0, "R9", "no frame after busy-time request", busy, 0);
      chk(cmd_rdata[25:16] === {5'h11, 5'h02}, "R9", "fields untouched by busy-time request",
          cmd_rdata[25:16], {5'h11, 5'h02});

      // R9: simultaneous requests, command word wins
      mon_wr = 1'b1; mon_resp = 16'h0;
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = {4'b0000, 2'b01, 5'h05, 5'h06, 16'h3C3C};
      req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h19; req_reg = 5'h18;
      @(negedge clk);
      cmd_we = 1'b0; req_valid = 1'b0;
      chk(cmd_rdata[26] === 1'b1, "R9", "command word won arbitration", cmd_rdata[26], 1);
      finish_txn(1'b1, 5'h05, 5'h06, 16'h3C3C, 16'h0);

      // R8: read sets done, a new command clears it
      txn(1'b1, 1'b0, 5'h01, 5'h01, 16'h0, 16'h5AA5);
      launch(1'b1, 1'b1, 5'h02, 5'h03, 16'h0001, 16'h0);
      finish_txn(1'b1, 5'h02, 5'h03, 16'h0001, 16'h0);

      // constrained random mix on both fronts
      for (int i = 0; i < 24; i++) begin
         bit vc, w;
         logic [4:0] p, r;
         logic [15:0] d, rs;
         vc = $urandom % 2;
         w  = $urandom % 2;
         p  = 5'($urandom);
         r  = 5'($urandom);
         d  = w ? 16'($urandom) : 16'h0;
         rs = 16'($urandom);
         txn(vc, w, p, r, d, rs);
      end

      chk(run_bad == 0, "R10", "MDC low/high run lengths", run_bad, 0);
      summary();
   end
endmodule